// File: doc/BRIEF.md
# Dual-Bank Swallow-Counter Synthesizer Divider

This block supplies the two divided-down signals that a PLL phase detector compares. The feedback path divides the oscillator input by a 14-bit value M, and the reference path divides the reference input by an 11-bit value R. Each path emits a single-clock pulse once per division period. Both inputs arrive as per-cycle enables in one clock domain. `vco_en` marks one oscillator cycle and `ref_en` marks one reference cycle.

The feedback path is built as a dual-modulus divider. The upper ten bits of the divide word form a main count P, and the lower four bits form a swallow count A. A prescaler model divides by 17 while swallow periods remain and by 16 after that, so one full period spans 16·P + A input cycles. The block holds two banks of (M, R) values, and a select input chooses between them. A change of bank is picked up by each path only when that path reloads, so a period never ends early. A value outside the legal range is clamped to the nearest limit and raises a flag. A synchronous reset, used for shutdown, reloads both paths from the selected bank.

Top module: `synth_divider_pair`

## Requirements
- R1: With divide word M (bits 13:4 = P, bits 3:0 = A), `fb_pulse` goes high for one clock once per M cycles in which `vco_en` was high. M = 16·P + A.
- R2: The prescaler count never exceeds 16. It reaches its 17th state (16) only while swallow periods remain, and it wraps at 15 once the swallow count is zero.
- R3: `ref_pulse` goes high for one clock once per R cycles in which `ref_en` was high.
- R4: `bank_sel` = 1 selects `m1_word`/`r1_word`. `bank_sel` = 0 selects `m2_word`/`r2_word`.
- R5: A change of `bank_sel` or of the selected words takes effect in each path only at that path's next reload. The period in progress completes with the old value.
- R6: An M value below 256 is loaded as 256. `m_range_err` is updated at every feedback reload and is 1 exactly when the value loaded at the last reload was clamped.
- R7: An R value below 2 is loaded as 2. `r_range_err` is updated at every reference reload and is 1 exactly when the value loaded at the last reload was clamped.
- R8: While `rst` is high, both pulses are 0, both counters reload from the selected bank, and both error flags take the range state of that bank. The first pulse after reset comes after a full M (or R) enabled cycles.
- R9: A pulse never occurs in the clock after a cycle whose enable was low. With an enable held low, its path produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset / shutdown |
| bank_sel | input | 1 | 1 selects bank 1, 0 selects bank 2 |
| m1_word | input | 14 | Bank 1 feedback divide word {P, A} |
| m2_word | input | 14 | Bank 2 feedback divide word {P, A} |
| r1_word | input | 11 | Bank 1 reference divide value |
| r2_word | input | 11 | Bank 2 reference divide value |
| vco_en | input | 1 | One oscillator input cycle |
| ref_en | input | 1 | One reference input cycle |
| fb_pulse | output | 1 | Feedback comparison pulse |
| ref_pulse | output | 1 | Reference comparison pulse |
| m_range_err | output | 1 | Last loaded M was clamped |
| r_range_err | output | 1 | Last loaded R was clamped |

## Verification
Each pulse and each error flag is registered. Each one appears in the clock that follows the rising edge at which the terminal enabled cycle, or the reset, was sampled. The bench reference model advances at that same rising edge from the sampled inputs and compares all four outputs at the following falling edge, so the expected result and the design's result refer to the same edge. Bank switches and word changes are driven mid-period. The model's own reload-time latching then checks that the old period completes first.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

    localparam int SWAL_W   = 4;
    localparam int MAIN_W   = 10;
    localparam int M_W      = SWAL_W + MAIN_W;
    localparam int R_W      = 11;
    localparam int PRESC_LO = 1 << SWAL_W;          // low modulus, high is +1
    localparam int PRE_W    = $clog2(PRESC_LO + 1);
    localparam int M_MIN    = 256;
    localparam int R_MIN    = 2;

    typedef struct packed {
        logic [MAIN_W-1:0] main;
        logic [SWAL_W-1:0] swal;
    } fb_word_t;

    typedef logic [R_W-1:0] ref_word_t;

    typedef struct packed {
        fb_word_t  m;
        ref_word_t r;
        logic      m_low;
        logic      r_low;
    } bank_cfg_t;

    function automatic bank_cfg_t legalize(input logic [M_W-1:0] m_raw,
                                           input logic [R_W-1:0] r_raw);
        bank_cfg_t c;
        c.m_low = (m_raw < M_W'(M_MIN));
        c.r_low = (r_raw < R_W'(R_MIN));
        c.m     = c.m_low ? fb_word_t'(M_W'(M_MIN)) : fb_word_t'(m_raw);
        c.r     = c.r_low ? ref_word_t'(R_W'(R_MIN)) : r_raw;
        return c;
    endfunction

endpackage

// File: rtl/synth_bank_select.sv
module synth_bank_select
    import synth_div_pkg::*;
(
    input  logic              bank_sel,
    input  logic [M_W-1:0]    m1_word,
    input  logic [M_W-1:0]    m2_word,
    input  logic [R_W-1:0]    r1_word,
    input  logic [R_W-1:0]    r2_word,
    output bank_cfg_t         cfg
);
    localparam int N_BANK = 2;

    logic [M_W-1:0] m_raw [N_BANK];
    logic [R_W-1:0] r_raw [N_BANK];
    bank_cfg_t      legal [N_BANK];

    assign m_raw[0] = m1_word;
    assign m_raw[1] = m2_word;
    assign r_raw[0] = r1_word;
    assign r_raw[1] = r2_word;

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        assign legal[b] = legalize(m_raw[b], r_raw[b]);
    end

    // high select picks the first bank
    assign cfg = bank_sel ? legal[0] : legal[1];

endmodule

// File: rtl/synth_fb_divider.sv
module synth_fb_divider
    import synth_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              vco_en,
    input  fb_word_t          load_word,
    input  logic              load_err,
    output logic              fb_pulse,
    output logic              m_err,
    output logic [PRE_W-1:0]  pre_cnt,
    output logic [SWAL_W-1:0] swal_left,
    output logic [MAIN_W-1:0] main_left
);
    localparam logic [PRE_W-1:0]  LAST_LO = PRE_W'(PRESC_LO - 1);
    localparam logic [PRE_W-1:0]  LAST_HI = PRE_W'(PRESC_LO);
    localparam logic [MAIN_W-1:0] MAIN_ONE = MAIN_W'(1);

    logic [PRE_W-1:0] pre_last;
    logic             presc_wrap;
    logic             terminal;

    always_comb begin
        pre_last   = (swal_left != '0) ? LAST_HI : LAST_LO;
        presc_wrap = vco_en && (pre_cnt == pre_last);
        terminal   = presc_wrap && (main_left == MAIN_ONE);
    end

    always_ff @(posedge clk) begin
        if (rst || terminal) begin
            pre_cnt   <= '0;
            swal_left <= load_word.swal;
            main_left <= load_word.main;
            m_err     <= load_err;
            fb_pulse  <= terminal && !rst;
        end else begin
            fb_pulse <= 1'b0;
            if (presc_wrap) begin
                pre_cnt   <= '0;
                main_left <= main_left - MAIN_ONE;
                if (swal_left != '0)
                    swal_left <= swal_left - SWAL_W'(1);
            end else if (vco_en) begin
                pre_cnt <= pre_cnt + PRE_W'(1);
            end
        end
    end

endmodule

// File: rtl/synth_ref_divider.sv
module synth_ref_divider
    import synth_div_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ref_en,
    input  ref_word_t       load_val,
    input  logic            load_err,
    output logic            ref_pulse,
    output logic            r_err,
    output logic [R_W-1:0]  r_left
);
    localparam logic [R_W-1:0] R_ONE = R_W'(1);

    logic terminal;

    assign terminal = ref_en && (r_left == R_ONE);

    always_ff @(posedge clk) begin
        if (rst || terminal) begin
            r_left    <= load_val;
            r_err     <= load_err;
            ref_pulse <= terminal && !rst;
        end else begin
            ref_pulse <= 1'b0;
            if (ref_en)
                r_left <= r_left - R_ONE;
        end
    end

endmodule

// File: rtl/synth_divider_pair.sv
module synth_divider_pair
    import synth_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bank_sel,
    input  logic [M_W-1:0]    m1_word,
    input  logic [M_W-1:0]    m2_word,
    input  logic [R_W-1:0]    r1_word,
    input  logic [R_W-1:0]    r2_word,
    input  logic              vco_en,
    input  logic              ref_en,
    output logic              fb_pulse,
    output logic              ref_pulse,
    output logic              m_range_err,
    output logic              r_range_err
);
    bank_cfg_t         cfg;
    logic [PRE_W-1:0]  fb_pre_cnt;
    logic [SWAL_W-1:0] fb_swal_left;
    logic [MAIN_W-1:0] fb_main_left;
    logic [R_W-1:0]    rd_left;

    synth_bank_select u_bank (
        .bank_sel (bank_sel),
        .m1_word  (m1_word),
        .m2_word  (m2_word),
        .r1_word  (r1_word),
        .r2_word  (r2_word),
        .cfg      (cfg)
    );

    synth_fb_divider u_fb (
        .clk       (clk),
        .rst       (rst),
        .vco_en    (vco_en),
        .load_word (cfg.m),
        .load_err  (cfg.m_low),
        .fb_pulse  (fb_pulse),
        .m_err     (m_range_err),
        .pre_cnt   (fb_pre_cnt),
        .swal_left (fb_swal_left),
        .main_left (fb_main_left)
    );

    synth_ref_divider u_ref (
        .clk       (clk),
        .rst       (rst),
        .ref_en    (ref_en),
        .load_val  (cfg.r),
        .load_err  (cfg.r_low),
        .ref_pulse (ref_pulse),
        .r_err     (r_range_err),
        .r_left    (rd_left)
    );

endmodule

// File: rtl/synth_divider_pair_chk.sv
module synth_divider_pair_chk
    import synth_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              vco_en,
    input  logic              ref_en,
    input  logic              fb_pulse,
    input  logic              ref_pulse,
    input  logic              m_range_err,
    input  logic              r_range_err,
    input  logic [PRE_W-1:0]  pre_cnt,
    input  logic [SWAL_W-1:0] swal_left,
    input  logic [MAIN_W-1:0] main_left,
    input  logic [R_W-1:0]    r_left
);
    localparam int MAIN_FLOOR = M_MIN / PRESC_LO;

    p_prescale_bound_r2: assert property (@(posedge clk) disable iff (rst)
        pre_cnt <= PRE_W'(PRESC_LO));

    p_hi_modulus_r2: assert property (@(posedge clk) disable iff (rst)
        (pre_cnt == PRE_W'(PRESC_LO)) |-> (swal_left != '0));

    p_fb_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
        fb_pulse |-> $past(vco_en));

    p_ref_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |-> $past(ref_en));

    p_fb_single_r1: assert property (@(posedge clk) disable iff (rst)
        fb_pulse |=> !fb_pulse);

    p_ref_single_r3: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |=> !ref_pulse);

    p_mload_legal_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) || fb_pulse) |-> (main_left >= MAIN_W'(MAIN_FLOOR)));

    p_rload_legal_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) || ref_pulse) |-> (r_left >= R_W'(R_MIN)));

    p_merr_at_reload_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(m_range_err) |-> ($past(rst) || fb_pulse));

    p_rerr_at_reload_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(r_range_err) |-> ($past(rst) || ref_pulse));

    p_reset_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!fb_pulse && !ref_pulse));

endmodule

bind synth_divider_pair synth_divider_pair_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .vco_en      (vco_en),
    .ref_en      (ref_en),
    .fb_pulse    (fb_pulse),
    .ref_pulse   (ref_pulse),
    .m_range_err (m_range_err),
    .r_range_err (r_range_err),
    .pre_cnt     (fb_pre_cnt),
    .swal_left   (fb_swal_left),
    .main_left   (fb_main_left),
    .r_left      (rd_left)
);

// File: tb/synth_divider_pair_tb_top.sv
module synth_divider_pair_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bank_sel = 1'b1;
    logic [13:0] m1_word = 14'd273;
    logic [13:0] m2_word = 14'd300;
    logic [10:0] r1_word = 11'd5;
    logic [10:0] r2_word = 11'd3;
    logic        vco_en = 1'b0;
    logic        ref_en = 1'b0;
    logic        fb_pulse, ref_pulse, m_range_err, r_range_err;

    int checks = 0;
    int errors = 0;
    bit chk_on = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    synth_divider_pair dut_i (
        .clk(clk), .rst(rst), .bank_sel(bank_sel),
        .m1_word(m1_word), .m2_word(m2_word),
        .r1_word(r1_word), .r2_word(r2_word),
        .vco_en(vco_en), .ref_en(ref_en),
        .fb_pulse(fb_pulse), .ref_pulse(ref_pulse),
        .m_range_err(m_range_err), .r_range_err(r_range_err)
    );

    // behavioural reference model
    int  mcnt, mval, rcnt, rval;
    bit  e_fb, e_ref, e_merr, e_rerr;

    function automatic int lim_m(int raw);
        return (raw < 256) ? 256 : raw;
    endfunction
    function automatic int lim_r(int raw);
        return (raw < 2) ? 2 : raw;
    endfunction

    always @(posedge clk) begin
        int sm, sr;
        sm = bank_sel ? int'(m1_word) : int'(m2_word);
        sr = bank_sel ? int'(r1_word) : int'(r2_word);
        e_fb  = 1'b0;
        e_ref = 1'b0;
        if (rst) begin
            mcnt = 0; mval = lim_m(sm); e_merr = (sm < 256);
            rcnt = 0; rval = lim_r(sr); e_rerr = (sr < 2);
        end else begin
            if (vco_en) begin
                mcnt++;
                if (mcnt == mval) begin
                    e_fb = 1'b1; mcnt = 0; mval = lim_m(sm); e_merr = (sm < 256);
                end
            end
            if (ref_en) begin
                rcnt++;
                if (rcnt == rval) begin
                    e_ref = 1'b1; rcnt = 0; rval = lim_r(sr); e_rerr = (sr < 2);
                end
            end
        end
    end

    task automatic check1(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            check1(cur_req, "fb_pulse", fb_pulse, e_fb);
            check1(cur_req, "ref_pulse", ref_pulse, e_ref);
            check1(cur_req, "m_range_err", m_range_err, e_merr);
            check1(cur_req, "r_range_err", r_range_err, e_rerr);
        end
    end

    logic [15:0] lfsr = 16'hACE1;
    always @(posedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

    // mode 0: both always on, 1: pseudo-random, 2: feedback held off
    task automatic run(int n, int mode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            case (mode)
                0: begin vco_en = 1'b1; ref_en = 1'b1; end
                1: begin vco_en = lfsr[3]; ref_en = lfsr[9] | lfsr[1]; end
                default: begin vco_en = 1'b0; ref_en = lfsr[5]; end
            endcase
        end
    endtask

    task automatic reset_checks(bit m_low, bit r_low);
        // sampled one falling edge after the reset edge
        check1("R8", "reset fb_pulse", fb_pulse, 1'b0);
        check1("R8", "reset ref_pulse", ref_pulse, 1'b0);
        check1("R8", "reset m_range_err", m_range_err, m_low);
        check1("R8", "reset r_range_err", r_range_err, r_low);
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        reset_checks(1'b0, 1'b0);
        rst = 1'b0;
        chk_on = 1'b1;

        cur_req = "R1";  run(3000, 0);     // A=1, P=17 full-rate
        cur_req = "R3";  r1_word = 11'd2; run(2000, 1);
        cur_req = "R2";  m1_word = 14'd256; run(2000, 0);   // swallow zero
        m1_word = 14'd271;  run(2000, 1);                   // swallow 15
        cur_req = "R4";  bank_sel = 1'b0; run(3000, 1);
        cur_req = "R5";  run(137, 0); bank_sel = 1'b1; m1_word = 14'd290; r1_word = 11'd7;
        run(1500, 0);
        bank_sel = 1'b0; run(40, 0); m2_word = 14'd320; run(1500, 1);
        cur_req = "R6";  m2_word = 14'd10;  run(1500, 0);
        m2_word = 14'd255; run(1000, 0);
        m2_word = 14'd256; run(1000, 0);
        cur_req = "R7";  r2_word = 11'd1; run(300, 1);
        r2_word = 11'd0; run(300, 0);
        r2_word = 11'd2; run(300, 0);
        cur_req = "R9";  run(600, 2);
        cur_req = "R8";  run(77, 0);
        chk_on = 1'b0;
        @(negedge clk); rst = 1'b1; m2_word = 14'd100; r2_word = 11'd0;
        @(negedge clk);
        reset_checks(1'b1, 1'b1);
        rst = 1'b0;
        chk_on = 1'b1;
        run(2000, 0);
        cur_req = "R1";  m2_word = 14'd16383; r2_word = 11'd2047; run(20000, 0);
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule